// File: doc/BRIEF.md
# Memory-mapped window to legacy port and indexed register bridge

This block sits behind a 4 KiB memory-mapped register window and converts each upstream access into operations on two downstream buses. A 32-byte slice of the window is forwarded, byte by byte, to an 8-bit legacy port bus whose port numbers start at 0x3C0. A second slice holds eleven 16-bit extension registers. These are reached through an indexed bus: the index is written first, and a single 16-bit data read or write follows.

The requester presents an offset, a size, a direction, write data and a one-cycle valid. It then waits for a one-cycle done pulse. Wider accesses are split into ordered sub-operations in little-endian order, so a word write to a legacy index/data port pair sets the index before the data. A configuration input can switch the whole window off, and then every access is treated as unmapped. While a sequence is running, further valid requests are ignored.

Top module: `mmio_legacy_bridge`

## Requirements
- R1: While reset is asserted, all downstream strobes (`lp_rd`, `lp_wr`, `ix_idx_wr`, `ix_rd`, `ix_wr`) and `req_done` are low, and `req_rdata` is zero.
- R2: `req_size` encodes 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes. A 1-byte access at an offset O in 0x400..0x41F performs one port operation at port 0x3C0 + (O - 0x400). Write data comes from `req_wdata[7:0]`, and read data is returned in `req_rdata[7:0]` with the upper bits zero.
- R3: A 2-byte legacy write drives the low byte to port N in the first operation cycle. In the next cycle it drives the high byte (`req_wdata[15:8]`) to port N+1.
- R4: A 2-byte legacy read reads port N, then port N+1. The second byte is returned in bits 15:8.
- R5: An access whose start offset O lies in 0x500..0x515 writes index (O - 0x500) >> 1 on `ix_index` with `ix_idx_wr`. In the following cycle it performs one 16-bit data read (`ix_rd`) or write (`ix_wr`, data from `req_wdata[15:0]`).
- R6: A 1-byte extension read returns the high byte of the register when O is odd and the low byte when O is even, in `req_rdata[7:0]`. A 1-byte extension write produces no downstream strobe.
- R7: A 4-byte access is handled as two 2-byte sub-accesses, at O and then at O+2. Each sub-access is decoded on its own start offset, and its result is placed in bits 15:0 and then in bits 31:16.
- R8: A sub-access whose start offset lies in neither region produces no downstream strobe and reads as zero, yet the access still completes.
- R9: With `win_en` low when an access is accepted, the whole access behaves as unmapped.
- R10: `req_done` is high for exactly one cycle. An access accepted at a clock edge shows done 3 cycles later for 1- or 2-byte sizes and 5 cycles later for 4-byte sizes. `req_rdata` is zero for writes. A `req_valid` raised while a sequence runs is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_en | input | 1 | Window enable; low makes every access unmapped |
| req_valid | input | 1 | Upstream request, taken only when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2/3 = 4 bytes |
| req_offset | input | 12 | Byte offset in the window |
| req_wdata | input | 32 | Write data, little-endian lanes |
| req_done | output | 1 | One-cycle completion pulse |
| req_rdata | output | 32 | Read result, valid with req_done |
| lp_port | output | 16 | Legacy port number |
| lp_rd | output | 1 | Legacy byte read strobe |
| lp_wr | output | 1 | Legacy byte write strobe |
| lp_wdata | output | 8 | Legacy write byte |
| lp_rdata | input | 8 | Legacy read byte, valid in the lp_rd cycle |
| ix_index | output | 16 | Extension register index |
| ix_idx_wr | output | 1 | Index write strobe |
| ix_rd | output | 1 | Extension data read strobe |
| ix_wr | output | 1 | Extension data write strobe |
| ix_wdata | output | 16 | Extension write data |
| ix_rdata | input | 16 | Extension read data, valid in the ix_rd cycle |

## Verification
Take the clock edge that samples `req_valid` as edge 0. The first sub-operation appears in the cycle after edge 0 and the second in the cycle after that. A 4-byte access places its second pair in the third and fourth cycles, and done follows the last pair by one cycle. The bench's reference model turns every request into a table of expected bus activity keyed by absolute cycle number, and leaves every other cycle empty. It compares the strobes, the port, index and data fields those strobes qualify, and the done-qualified read data once per cycle, half a period after the edge. A strobe that is early, late or unexpected therefore fails in the exact cycle where it appears.

// File: rtl/mmio_legacy_bridge.sv
module mmio_legacy_bridge #(
  parameter int OFF_W = 12,
  parameter logic [OFF_W-1:0] LEG_BASE = 'h400,
  parameter int LEG_SPAN = 32,
  parameter logic [15:0] PORT_BASE = 16'h03C0,
  parameter logic [OFF_W-1:0] EXT_BASE = 'h500,
  parameter int EXT_REGS = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_en,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [1:0]       req_size,
  input  logic [OFF_W-1:0] req_offset,
  input  logic [31:0]      req_wdata,
  output logic             req_done,
  output logic [31:0]      req_rdata,
  output logic [15:0]      lp_port,
  output logic             lp_rd,
  output logic             lp_wr,
  output logic [7:0]       lp_wdata,
  input  logic [7:0]       lp_rdata,
  output logic [15:0]      ix_index,
  output logic             ix_idx_wr,
  output logic             ix_rd,
  output logic             ix_wr,
  output logic [15:0]      ix_wdata,
  input  logic [15:0]      ix_rdata
);
  localparam logic [OFF_W-1:0] LEG_TOP = LEG_BASE + OFF_W'(LEG_SPAN);
  localparam logic [OFF_W-1:0] EXT_TOP = EXT_BASE + OFF_W'(2 * EXT_REGS);

  typedef enum logic [1:0] {S_IDLE, S_OP0, S_OP1, S_FIN} st_t;

  st_t              st;
  logic             half, wr_q, en_q;
  logic [1:0]       sz_q;
  logic [OFF_W-1:0] off_q;
  logic [31:0]      wd_q, rd_q;

  logic [OFF_W-1:0] sub_off;
  logic             in_leg, in_ext, byte_acc, ext_go, op0, op1;
  logic [15:0]      port_n;
  logic [OFF_W-1:0] ext_rel;

  assign sub_off  = off_q + {{(OFF_W-2){1'b0}}, half, 1'b0};
  assign byte_acc = (sz_q == 2'd0);
  assign in_leg   = en_q && (sub_off >= LEG_BASE) && (sub_off < LEG_TOP);
  assign in_ext   = en_q && (sub_off >= EXT_BASE) && (sub_off < EXT_TOP);
  assign ext_go   = in_ext && !(wr_q && byte_acc);
  assign op0      = (st == S_OP0);
  assign op1      = (st == S_OP1);
  assign port_n   = PORT_BASE + 16'(sub_off - LEG_BASE);
  assign ext_rel  = sub_off - EXT_BASE;

  assign lp_rd    = in_leg && !wr_q && (op0 || (op1 && !byte_acc));
  assign lp_wr    = in_leg &&  wr_q && (op0 || (op1 && !byte_acc));
  assign lp_port  = op1 ? port_n + 16'd1 : port_n;
  assign lp_wdata = half ? (op1 ? wd_q[31:24] : wd_q[23:16])
                         : (op1 ? wd_q[15:8]  : wd_q[7:0]);

  assign ix_index  = 16'(ext_rel >> 1);
  assign ix_idx_wr = op0 && ext_go;
  assign ix_rd     = op1 && ext_go && !wr_q;
  assign ix_wr     = op1 && ext_go &&  wr_q;
  assign ix_wdata  = half ? wd_q[31:16] : wd_q[15:0];

  assign req_done  = (st == S_FIN);
  assign req_rdata = req_done ? rd_q : 32'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      half  <= 1'b0;
      wr_q  <= 1'b0;
      en_q  <= 1'b0;
      sz_q  <= 2'd0;
      off_q <= '0;
      wd_q  <= 32'd0;
      rd_q  <= 32'd0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          st    <= S_OP0;
          half  <= 1'b0;
          wr_q  <= req_write;
          en_q  <= win_en;
          sz_q  <= req_size;
          off_q <= req_offset;
          wd_q  <= req_wdata;
          rd_q  <= 32'd0;
        end
        S_OP0: begin
          if (lp_rd) begin
            if (half) rd_q[23:16] <= lp_rdata;
            else      rd_q[7:0]   <= lp_rdata;
          end
          st <= S_OP1;
        end
        S_OP1: begin
          if (lp_rd) begin
            if (half) rd_q[31:24] <= lp_rdata;
            else      rd_q[15:8]  <= lp_rdata;
          end
          if (ix_rd) begin
            if (byte_acc)  rd_q[7:0]   <= sub_off[0] ? ix_rdata[15:8] : ix_rdata[7:0];
            else if (half) rd_q[31:16] <= ix_rdata;
            else           rd_q[15:0]  <= ix_rdata;
          end
          if (sz_q[1] && !half) begin
            half <= 1'b1;
            st   <= S_OP0;
          end else begin
            st <= S_FIN;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({lp_rd, lp_wr, ix_idx_wr, ix_rd, ix_wr}) <= 1);  // R7
  AST_QUIET_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE || req_done) |-> !(lp_rd || lp_wr || ix_idx_wr || ix_rd || ix_wr));  // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |=> !req_done);  // R10
  AST_LEG_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    ((lp_wr && $past(lp_wr)) || (lp_rd && $past(lp_rd))) |-> lp_port == $past(lp_port) + 16'd1);  // R3
  AST_INDEX_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (ix_rd || ix_wr) |-> ($past(ix_idx_wr) && ix_index == $past(ix_index)));  // R5
  AST_INDEX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ix_idx_wr |-> ix_index < 16'(EXT_REGS));  // R5
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !(lp_rd || lp_wr || ix_idx_wr || ix_rd || ix_wr));  // R9
endmodule

// File: tb/tb_mmio_legacy_bridge.sv
module tb_mmio_legacy_bridge;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic win_en = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [1:0] req_size = 2'd0;
  logic [11:0] req_offset = 12'd0;
  logic [31:0] req_wdata = 32'd0;
  logic req_done;
  logic [31:0] req_rdata;
  logic [15:0] lp_port, ix_index, ix_wdata, ix_rdata;
  logic lp_rd, lp_wr, ix_idx_wr, ix_rd, ix_wr;
  logic [7:0] lp_wdata, lp_rdata;

  always #4 clk = ~clk;

  mmio_legacy_bridge dut (
    .clk(clk), .rst_n(rst_n), .win_en(win_en),
    .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
    .req_offset(req_offset), .req_wdata(req_wdata),
    .req_done(req_done), .req_rdata(req_rdata),
    .lp_port(lp_port), .lp_rd(lp_rd), .lp_wr(lp_wr), .lp_wdata(lp_wdata), .lp_rdata(lp_rdata),
    .ix_index(ix_index), .ix_idx_wr(ix_idx_wr), .ix_rd(ix_rd), .ix_wr(ix_wr),
    .ix_wdata(ix_wdata), .ix_rdata(ix_rdata)
  );

  function automatic logic [7:0] port_val(input logic [15:0] p);
    return p[7:0] ^ 8'h5A;
  endfunction
  function automatic logic [15:0] reg_val(input int idx);
    return 16'hB000 + 16'(idx) * 16'h0111;
  endfunction

  logic [15:0] cur_idx = 16'd0;
  always @(posedge clk) if (ix_idx_wr) cur_idx <= ix_index;
  assign lp_rdata = port_val(lp_port);
  assign ix_rdata = reg_val(int'(cur_idx));

  typedef struct packed {
    logic lr, lw, iw, ir, ixw, dn;
    logic [15:0] port;
    logic [7:0]  lwd;
    logic [15:0] idx;
    logic [15:0] iwd;
    logic [31:0] rd;
  } ev_t;

  ev_t exp_tab[int];
  int cyc = 0;
  int total = 0, bad = 0;
  string cur_tag = "R1";

  always @(posedge clk) cyc <= cyc + 1;

  function automatic ev_t mask(input ev_t e);
    ev_t m = e;
    if (!(e.lr || e.lw)) m.port = '0;
    if (!e.lw) m.lwd = '0;
    if (!e.iw) m.idx = '0;
    if (!e.ixw) m.iwd = '0;
    if (!e.dn) m.rd = '0;
    return m;
  endfunction

  always @(negedge clk) if (rst_n) begin
    ev_t o, x;
    o = mask('{lp_rd, lp_wr, ix_idx_wr, ix_rd, ix_wr, req_done, lp_port, lp_wdata, ix_index, ix_wdata, req_rdata});
    x = exp_tab.exists(cyc) ? mask(exp_tab[cyc]) : '0;
    total++;
    if (o !== x) begin
      bad++;
      $display("FAIL %s cycle %0d: actual=%h expected=%h", cur_tag, cyc, o, x);
    end
  end

  task automatic issue(input bit wr, input int size, input int off, input logic [31:0] wd, input string tag);
    int k, nb, halves, o, sub;
    logic [31:0] r;
    ev_t e;
    @(negedge clk);
    k = cyc;
    cur_tag = tag;
    req_valid = 1'b1; req_write = wr; req_size = 2'(size);
    req_offset = 12'(off); req_wdata = wd;
    nb = (size == 0) ? 1 : (size == 1) ? 2 : 4;
    halves = (nb == 4) ? 2 : 1;
    sub = (nb == 1) ? 1 : 2;
    r = 32'd0;
    for (int h = 0; h < halves; h++) begin
      o = off + 2 * h;
      if (win_en && o >= 'h400 && o <= 'h41F) begin
        e = '0;
        e.lr = !wr; e.lw = wr; e.port = 16'(16'h3C0 + o - 'h400);
        e.lwd = wd[16*h +: 8];
        exp_tab[k + 1 + 2*h] = e;
        if (!wr) r[16*h +: 8] = port_val(e.port);
        if (sub == 2) begin
          e.port = e.port + 16'd1;
          e.lwd = wd[16*h + 8 +: 8];
          exp_tab[k + 2 + 2*h] = e;
          if (!wr) r[16*h + 8 +: 8] = port_val(e.port);
        end
      end else if (win_en && o >= 'h500 && o <= 'h515 && !(wr && sub == 1)) begin
        e = '0; e.iw = 1'b1; e.idx = 16'((o - 'h500) >> 1);
        exp_tab[k + 1 + 2*h] = e;
        e = '0; e.ir = !wr; e.ixw = wr; e.iwd = wd[16*h +: 16];
        exp_tab[k + 2 + 2*h] = e;
        if (!wr) begin
          if (sub == 1) r[7:0] = (o % 2 == 1) ? reg_val((o - 'h500) >> 1) >> 8 : reg_val((o - 'h500) >> 1) & 16'h00FF;
          else r[16*h +: 16] = reg_val((o - 'h500) >> 1);
        end
      end
    end
    e = '0; e.dn = 1'b1; e.rd = wr ? 32'd0 : r;
    exp_tab[k + 1 + 2*halves] = e;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (2 * halves + 1) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if ({lp_rd, lp_wr, ix_idx_wr, ix_rd, ix_wr, req_done} !== 6'b0 || req_rdata !== 32'd0) begin
      bad++;
      $display("FAIL R1 reset: actual=%b/%h expected=0/0",
               {lp_rd, lp_wr, ix_idx_wr, ix_rd, ix_wr, req_done}, req_rdata);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    issue(1, 0, 'h404, 32'h0000_00C7, "R2");
    issue(0, 0, 'h41F, 32'd0, "R2");
    issue(1, 1, 'h414, 32'h0000_BEEF, "R3");
    issue(1, 1, 'h41F, 32'h0000_1234, "R3");
    issue(0, 1, 'h400, 32'd0, "R4");
    issue(0, 1, 'h40A, 32'd0, "R4");
    issue(1, 1, 'h508, 32'h0000_CAFE, "R5");
    issue(0, 1, 'h514, 32'd0, "R5");
    issue(0, 0, 'h503, 32'd0, "R6");
    issue(0, 0, 'h502, 32'd0, "R6");
    issue(1, 0, 'h506, 32'h0000_0077, "R6");
    issue(1, 2, 'h410, 32'hA1B2_C3D4, "R7");
    issue(0, 2, 'h500, 32'd0, "R7");
    issue(0, 3, 'h504, 32'd0, "R7");
    issue(0, 2, 'h41E, 32'd0, "R7");
    issue(1, 2, 'h50C, 32'h1111_2222, "R7");
    issue(0, 0, 'h200, 32'd0, "R8");
    issue(1, 1, 'h600, 32'hFFFF_FFFF, "R8");
    issue(0, 1, 'h516, 32'd0, "R8");
    issue(0, 2, 'hFFC, 32'd0, "R8");
    win_en = 1'b0;
    issue(0, 1, 'h404, 32'd0, "R9");
    issue(1, 1, 'h508, 32'h0000_5555, "R9");
    issue(0, 2, 'h500, 32'd0, "R9");
    win_en = 1'b1;

    begin
      int k;
      ev_t e;
      @(negedge clk);
      k = cyc; cur_tag = "R10";
      req_valid = 1'b1; req_write = 1'b0; req_size = 2'd0; req_offset = 12'h408; req_wdata = 32'd0;
      e = '0; e.lr = 1'b1; e.port = 16'h03C8; exp_tab[k + 1] = e;
      e = '0; e.dn = 1'b1; e.rd = {24'd0, port_val(16'h03C8)}; exp_tab[k + 3] = e;
      @(negedge clk);
      req_write = 1'b1; req_size = 2'd1; req_offset = 12'h404; req_wdata = 32'h0000_9999;
      @(negedge clk);
      req_size = 2'd2; req_offset = 12'h500;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (4) @(negedge clk);
    end

    issue(0, 1, 'h40E, 32'd0, "R10");
    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule